// File: doc/BRIEF.md
# Colour Lookup Table Host Access Controller

This block lets a processor reach a 256-entry, 24-bit colour lookup table and a small overlay colour table over an 8-bit register bus. It also holds the pixel read mask and the control word. Three select lines pick one of eight targets. Colour entries move as three bytes in red, green, blue order. Writes gather the red and green bytes in holding registers, and the blue byte commits the whole word. Reads are prefetched: each entry is copied into a 24-bit holding register before the host asks for its bytes.

An 8-bit pointer is shared by both tables. It advances by one after every blue byte, so a run of entries can be loaded or dumped after a single start address. Four of the select codes load this pointer. Each of them also chooses the table (main or overlay) and the direction (write or prefetching read). One control-word bit narrows every colour component to 6 bits.

Top module: `pal_host_ctrl`

## Requirements
- R1: After reset, reading the pointer returns 0x00, the pixel mask reads 0xFF, the control word reads 0x00 and rdata is 0x00.
- R2: A write with select 000, 011, 100 or 111 loads the pointer from wdata. A read with any of these four codes returns the current pointer.
- R3: With select 001, three data writes give red, green and blue in turn. During the blue write strobe, pal_we is 1, pal_waddr equals the pointer and pal_wdata is {red, green, blue}, with red in bits 23:16. pal_we is 0 during the red and green writes.
- R4: The pointer increments after each blue write and wraps from 0xFF to 0x00.
- R5: Writing the pointer with select 011 loads the addressed main-table entry into the holding register and sets the pointer to the written value plus one. The following data reads (001) return red, green, blue.
- R6: After each blue data read, the entry at the current pointer is prefetched and the pointer increments, so consecutive triples stream out in order.
- R7: Any pointer write resets the byte phase to red. A partly written triple is dropped without a table write.
- R8: With select 100 then three data writes on 101, the blue write pulses ovl_we with ovl_waddr equal to the low 4 bits of the pointer. This happens only when the pointer is 1 to 15; other pointer values give no overlay write and read back as zero.
- R9: Writing the pointer with select 111 prefetches the overlay entry, and data reads on 101 return its red, green and blue bytes with the same streaming as R6.
- R10: Select 010 writes and reads the pixel mask. Select 110 writes and reads the control word. Both are driven on pix_mask and ctrl_word.
- R11: While control-word bit 1 is 1, data bytes are stored with bits 7:6 cleared and data reads return bits 7:6 as zero.
- R12: rdata changes only one cycle after a read strobe and holds its value otherwise.
- R13: When rd_stb and wr_stb are both 1, only the write takes effect: rdata is unchanged and the read does not advance the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 3 | Target select code |
| rd_stb | input | 1 | Single-cycle read strobe |
| wr_stb | input | 1 | Single-cycle write strobe |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| pal_we | output | 1 | Main table write enable |
| pal_waddr | output | 8 | Main table write address |
| pal_wdata | output | 24 | Main table write word |
| ovl_we | output | 1 | Overlay table write enable |
| ovl_waddr | output | 4 | Overlay table write address |
| ovl_wdata | output | 24 | Overlay table write word |
| pix_mask | output | 8 | Pixel read mask |
| ctrl_word | output | 8 | Control word |

## Verification
The table write ports are combinational from the strobe. They are due in the same cycle as the blue write, so the bench drives each strobe just after a falling edge and checks the write ports 1 ns later, before the rising edge that commits them. A read byte is registered: it appears after the rising edge that samples rd_stb. The driver queues the expected byte when it raises the strobe, and a monitor pops and compares it at the next falling edge. Pointer and prefetch effects are checked through later reads of the pointer and data codes. Each stimulus is therefore observed only after every register on its path has loaded.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int ADDR_W     = 8;
    localparam int COMP_W     = 8;
    localparam int NCOMP      = 3;
    localparam int WORD_W     = COMP_W * NCOMP;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int OVL_N      = 15;
    localparam int OVL_AW     = $clog2(OVL_N + 1);
    localparam int NARROW_BIT = 1;
    localparam int KEEP_W     = COMP_W - 2;

    localparam logic [1:0] PH_R = 2'd0;
    localparam logic [1:0] PH_G = 2'd1;
    localparam logic [1:0] PH_B = 2'd2;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic [1:0]        phase;
        logic              ovl;
        logic [COMP_W-1:0] wr_r;
        logic [COMP_W-1:0] wr_g;
        logic [WORD_W-1:0] hold;
        logic [COMP_W-1:0] mask;
        logic [COMP_W-1:0] cmd;
        logic [COMP_W-1:0] rdata;
    } seq_t;
endpackage

// File: rtl/pal_sel_decode.sv
module pal_sel_decode (
    input  logic [2:0] sel_i,
    output logic       is_addr_o,
    output logic       addr_rd_o,
    output logic       addr_ovl_o,
    output logic       is_data_o,
    output logic       data_ovl_o,
    output logic       is_mask_o,
    output logic       is_cmd_o
);
    always_comb begin
        is_addr_o  = 1'b0;
        addr_rd_o  = 1'b0;
        addr_ovl_o = 1'b0;
        is_data_o  = 1'b0;
        data_ovl_o = 1'b0;
        is_mask_o  = 1'b0;
        is_cmd_o   = 1'b0;
        case (sel_i)
            3'b000: is_addr_o = 1'b1;
            3'b011: begin is_addr_o = 1'b1; addr_rd_o = 1'b1; end
            3'b100: begin is_addr_o = 1'b1; addr_ovl_o = 1'b1; end
            3'b111: begin is_addr_o = 1'b1; addr_rd_o = 1'b1; addr_ovl_o = 1'b1; end
            3'b001: is_data_o = 1'b1;
            3'b101: begin is_data_o = 1'b1; data_ovl_o = 1'b1; end
            3'b010: is_mask_o = 1'b1;
            default: is_cmd_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int WW  = WORD_W,
    parameter int ON  = OVL_N,
    parameter int OAW = OVL_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pal_we_i,
    input  logic [AW-1:0] pal_waddr_i,
    input  logic [WW-1:0] pal_wdata_i,
    input  logic          ovl_we_i,
    input  logic [OAW-1:0] ovl_waddr_i,
    input  logic [WW-1:0] ovl_wdata_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [WW-1:0] pal_rd_o,
    output logic [WW-1:0] ovl_rd_o
);
    localparam int NENT = 1 << AW;

    logic [WW-1:0] pal_mem [NENT];
    logic [WW-1:0] ovl_ent [1:ON];

    always_ff @(posedge clk) begin
        if (pal_we_i) pal_mem[pal_waddr_i] <= pal_wdata_i;
    end

    assign pal_rd_o = pal_mem[rd_addr_i];

    for (genvar i = 1; i <= ON; i++) begin : g_ovl
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ovl_ent[i] <= '0;
            end else if (ovl_we_i && ovl_waddr_i == OAW'(i)) begin
                ovl_ent[i] <= ovl_wdata_i;
            end
        end
    end

    always_comb begin
        ovl_rd_o = '0;
        for (int i = 1; i <= ON; i++) begin
            if (rd_addr_i == AW'(i)) ovl_rd_o = ovl_ent[i];
        end
    end
endmodule

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_i,
    input  logic               wr_i,
    input  logic [COMP_W-1:0]  wdata_i,
    input  logic               is_addr_i,
    input  logic               addr_rd_i,
    input  logic               addr_ovl_i,
    input  logic               is_data_i,
    input  logic               data_ovl_i,
    input  logic               is_mask_i,
    input  logic               is_cmd_i,
    input  logic [WORD_W-1:0]  pal_rd_i,
    input  logic [WORD_W-1:0]  ovl_rd_i,
    output logic [ADDR_W-1:0]  look_addr_o,
    output logic               pal_we_o,
    output logic [ADDR_W-1:0]  pal_waddr_o,
    output logic [WORD_W-1:0]  pal_wdata_o,
    output logic               ovl_we_o,
    output logic [OVL_AW-1:0]  ovl_waddr_o,
    output logic [WORD_W-1:0]  ovl_wdata_o,
    output logic [COMP_W-1:0]  rdata_o,
    output logic [COMP_W-1:0]  mask_o,
    output logic [COMP_W-1:0]  cmd_o
);
    localparam logic [COMP_W-1:0] KEEP = {2'b00, {KEEP_W{1'b1}}};

    seq_t q, d;
    logic              look_ovl;
    logic              narrow;
    logic              ovl_ok;
    logic              prefetch;
    logic [COMP_W-1:0] wbyte;
    logic [COMP_W-1:0] cur_comp;

    // lookup address: a read-mode pointer write looks at the new value
    always_comb begin
        if (wr_i && is_addr_i) begin
            look_addr_o = wdata_i;
            look_ovl    = addr_ovl_i;
        end else begin
            look_addr_o = q.ptr;
            look_ovl    = q.ovl;
        end
    end

    always_comb begin
        narrow = q.cmd[NARROW_BIT];
        wbyte  = narrow ? (wdata_i & KEEP) : wdata_i;
        ovl_ok = (q.ptr >= ADDR_W'(1)) && (q.ptr <= ADDR_W'(OVL_N));
        case (q.phase)
            PH_R:    cur_comp = q.hold[WORD_W-1 -: COMP_W];
            PH_G:    cur_comp = q.hold[2*COMP_W-1 -: COMP_W];
            default: cur_comp = q.hold[COMP_W-1:0];
        endcase
        if (narrow) cur_comp = cur_comp & KEEP;
    end

    always_comb begin
        d        = q;
        pal_we_o = 1'b0;
        ovl_we_o = 1'b0;
        prefetch = 1'b0;
        if (wr_i) begin
            if (is_addr_i) begin
                d.ptr   = wdata_i;
                d.phase = PH_R;
                d.ovl   = addr_ovl_i;
                if (addr_rd_i) begin
                    prefetch = 1'b1;
                    d.ptr    = wdata_i + ADDR_W'(1);
                end
            end else if (is_data_i) begin
                case (q.phase)
                    PH_R: begin d.wr_r = wbyte; d.phase = PH_G; end
                    PH_G: begin d.wr_g = wbyte; d.phase = PH_B; end
                    default: begin
                        if (data_ovl_i) ovl_we_o = ovl_ok;
                        else            pal_we_o = 1'b1;
                        d.ptr   = q.ptr + ADDR_W'(1);
                        d.phase = PH_R;
                    end
                endcase
            end else if (is_mask_i) begin
                d.mask = wdata_i;
            end else if (is_cmd_i) begin
                d.cmd = wdata_i;
            end
        end else if (rd_i) begin
            if (is_addr_i) begin
                d.rdata = q.ptr;
            end else if (is_mask_i) begin
                d.rdata = q.mask;
            end else if (is_cmd_i) begin
                d.rdata = q.cmd;
            end else if (is_data_i) begin
                d.rdata = cur_comp;
                if (q.phase == PH_R)      d.phase = PH_G;
                else if (q.phase == PH_G) d.phase = PH_B;
                else begin
                    prefetch = 1'b1;
                    d.ptr    = q.ptr + ADDR_W'(1);
                    d.phase  = PH_R;
                end
            end
        end
        if (prefetch) d.hold = look_ovl ? ovl_rd_i : pal_rd_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{ptr: '0, phase: PH_R, ovl: 1'b0, wr_r: '0, wr_g: '0,
                   hold: '0, mask: '1, cmd: '0, rdata: '0};
        end else begin
            q <= d;
        end
    end

    assign pal_waddr_o = q.ptr;
    assign pal_wdata_o = {q.wr_r, q.wr_g, wbyte};
    assign ovl_waddr_o = q.ptr[OVL_AW-1:0];
    assign ovl_wdata_o = {q.wr_r, q.wr_g, wbyte};
    assign rdata_o     = q.rdata;
    assign mask_o      = q.mask;
    assign cmd_o       = q.cmd;
endmodule

// File: rtl/pal_host_ctrl.sv
module pal_host_ctrl
    import pal_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         sel,
    input  logic               rd_stb,
    input  logic               wr_stb,
    input  logic [COMP_W-1:0]  wdata,
    output logic [COMP_W-1:0]  rdata,
    output logic               pal_we,
    output logic [ADDR_W-1:0]  pal_waddr,
    output logic [WORD_W-1:0]  pal_wdata,
    output logic               ovl_we,
    output logic [OVL_AW-1:0]  ovl_waddr,
    output logic [WORD_W-1:0]  ovl_wdata,
    output logic [COMP_W-1:0]  pix_mask,
    output logic [COMP_W-1:0]  ctrl_word
);
    logic is_addr, addr_rd, addr_ovl, is_data, data_ovl, is_mask, is_cmd;
    logic [ADDR_W-1:0] look_addr;
    logic [WORD_W-1:0] pal_rd, ovl_rd;

    pal_sel_decode u_dec (
        .sel_i      (sel),
        .is_addr_o  (is_addr),
        .addr_rd_o  (addr_rd),
        .addr_ovl_o (addr_ovl),
        .is_data_o  (is_data),
        .data_ovl_o (data_ovl),
        .is_mask_o  (is_mask),
        .is_cmd_o   (is_cmd)
    );

    pal_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_i        (rd_stb),
        .wr_i        (wr_stb),
        .wdata_i     (wdata),
        .is_addr_i   (is_addr),
        .addr_rd_i   (addr_rd),
        .addr_ovl_i  (addr_ovl),
        .is_data_i   (is_data),
        .data_ovl_i  (data_ovl),
        .is_mask_i   (is_mask),
        .is_cmd_i    (is_cmd),
        .pal_rd_i    (pal_rd),
        .ovl_rd_i    (ovl_rd),
        .look_addr_o (look_addr),
        .pal_we_o    (pal_we),
        .pal_waddr_o (pal_waddr),
        .pal_wdata_o (pal_wdata),
        .ovl_we_o    (ovl_we),
        .ovl_waddr_o (ovl_waddr),
        .ovl_wdata_o (ovl_wdata),
        .rdata_o     (rdata),
        .mask_o      (pix_mask),
        .cmd_o       (ctrl_word)
    );

    pal_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .pal_we_i    (pal_we),
        .pal_waddr_i (pal_waddr),
        .pal_wdata_i (pal_wdata),
        .ovl_we_i    (ovl_we),
        .ovl_waddr_i (ovl_waddr),
        .ovl_wdata_i (ovl_wdata),
        .rd_addr_i   (look_addr),
        .pal_rd_o    (pal_rd),
        .ovl_rd_o    (ovl_rd)
    );
endmodule

// File: rtl/pal_host_chk.sv
module pal_host_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  sel,
    input logic        rd_stb,
    input logic        wr_stb,
    input logic [7:0]  rdata,
    input logic        pal_we,
    input logic [23:0] pal_wdata,
    input logic        ovl_we,
    input logic [3:0]  ovl_waddr,
    input logic [7:0]  ctrl_word
);
    AST_PAL_WE_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we |-> (wr_stb && sel == 3'b001)); // R3
    AST_OVL_WE_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_we |-> (wr_stb && sel == 3'b101)); // R8
    AST_OVL_ADDR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_we |-> (ovl_waddr != 4'd0)); // R8
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb || wr_stb) |=> $stable(rdata)); // R12
    AST_NARROW_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (pal_we && ctrl_word[1]) |-> (pal_wdata[23:22] == 2'b00 &&
                                      pal_wdata[15:14] == 2'b00 &&
                                      pal_wdata[7:6] == 2'b00)); // R11
    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb) |-> (!pal_we && !ovl_we)); // R13
endmodule

bind pal_host_ctrl pal_host_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .rdata     (rdata),
    .pal_we    (pal_we),
    .pal_wdata (pal_wdata),
    .ovl_we    (ovl_we),
    .ovl_waddr (ovl_waddr),
    .ctrl_word (ctrl_word)
);

// File: tb/sim_pal_host_ctrl.sv
`timescale 1ns/1ps
module sim_pal_host_ctrl;
    localparam time HALF = 2.5ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  sel = 3'b000;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        pal_we;
    logic [7:0]  pal_waddr;
    logic [23:0] pal_wdata;
    logic        ovl_we;
    logic [3:0]  ovl_waddr;
    logic [23:0] ovl_wdata;
    logic [7:0]  pix_mask;
    logic [7:0]  ctrl_word;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic pend = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #HALF clk = ~clk;

    pal_host_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .wdata(wdata), .rdata(rdata), .pal_we(pal_we), .pal_waddr(pal_waddr),
        .pal_wdata(pal_wdata), .ovl_we(ovl_we), .ovl_waddr(ovl_waddr),
        .ovl_wdata(ovl_wdata), .pix_mask(pix_mask), .ctrl_word(ctrl_word)
    );

    task automatic check(input bit ok, input string tag, input logic [23:0] act,
                         input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: a read sampled at a rising edge is compared at the next falling edge
    always @(posedge clk) pend <= rst_n && rd_stb && !wr_stb;
    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected read", {16'h0, rdata}, 24'h0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rdata == e, t, {16'h0, rdata}, {16'h0, e});
            end
        end
    end

    task automatic rd(input logic [2:0] s, input logic [7:0] e, input string t);
        sel = s; rd_stb = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] v);
        sel = s; wdata = v; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wr_chk(input logic [2:0] s, input logic [7:0] v, input bit epw,
                          input bit eow, input logic [7:0] ea, input logic [23:0] ed,
                          input string t);
        sel = s; wdata = v; wr_stb = 1'b1;
        #1;
        check(pal_we == epw, {t, " pal_we"}, {23'h0, pal_we}, {23'h0, epw});
        check(ovl_we == eow, {t, " ovl_we"}, {23'h0, ovl_we}, {23'h0, eow});
        if (epw) begin
            check(pal_waddr == ea, {t, " pal_waddr"}, {16'h0, pal_waddr}, {16'h0, ea});
            check(pal_wdata == ed, {t, " pal_wdata"}, pal_wdata, ed);
        end
        if (eow) begin
            check(ovl_waddr == ea[3:0], {t, " ovl_waddr"}, {20'h0, ovl_waddr}, {20'h0, ea[3:0]});
            check(ovl_wdata == ed, {t, " ovl_wdata"}, ovl_wdata, ed);
        end
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        check(exp_q.size() == 0, "scoreboard drained", 24'(exp_q.size()), 24'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        done = 1'b1;
        $finish;
    endtask

    initial begin
        #(HALF * 2 * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        check(rdata == 8'h00, "R1 rdata", {16'h0, rdata}, 24'h0);
        check(pix_mask == 8'hFF, "R1 pix_mask", {16'h0, pix_mask}, 24'hFF);
        rd(3'b000, 8'h00, "R1 pointer");
        rd(3'b010, 8'hFF, "R1 mask");
        rd(3'b110, 8'h00, "R1 ctrl");

        // R2: pointer load and readback through every address code
        wr(3'b000, 8'h10);
        rd(3'b000, 8'h10, "R2 read 000");
        rd(3'b011, 8'h10, "R2 read 011");

        // R3: triple write at 0x10
        wr_chk(3'b001, 8'h11, 0, 0, 8'h00, 24'h0, "R3 red");
        wr_chk(3'b001, 8'h22, 0, 0, 8'h00, 24'h0, "R3 green");
        wr_chk(3'b001, 8'h33, 1, 0, 8'h10, 24'h112233, "R3 blue");
        rd(3'b000, 8'h11, "R4 increment");
        // R4: streaming load of 0x11 and 0x12
        wr(3'b001, 8'hAA); wr(3'b001, 8'hBB);
        wr_chk(3'b001, 8'hCC, 1, 0, 8'h11, 24'hAABBCC, "R4 next entry");
        wr(3'b001, 8'h44); wr(3'b001, 8'h55);
        wr_chk(3'b001, 8'h66, 1, 0, 8'h12, 24'h445566, "R4 third entry");
        // R4: wrap
        wr(3'b000, 8'hFF);
        wr(3'b001, 8'h01); wr(3'b001, 8'h02);
        wr_chk(3'b001, 8'h03, 1, 0, 8'hFF, 24'h010203, "R4 top entry");
        rd(3'b100, 8'h00, "R4 wrap");

        // R5/R6: prefetched read stream
        wr(3'b011, 8'h10);
        rd(3'b000, 8'h11, "R5 pointer plus one");
        rd(3'b001, 8'h11, "R5 red");
        rd(3'b001, 8'h22, "R5 green");
        rd(3'b001, 8'h33, "R5 blue");
        rd(3'b001, 8'hAA, "R6 red");
        rd(3'b001, 8'hBB, "R6 green");
        rd(3'b001, 8'hCC, "R6 blue");
        rd(3'b000, 8'h13, "R6 pointer");

        // R7: abandoned triple
        wr(3'b000, 8'h20);
        wr_chk(3'b001, 8'h77, 0, 0, 8'h00, 24'h0, "R7 partial red");
        wr_chk(3'b001, 8'h88, 0, 0, 8'h00, 24'h0, "R7 partial green");
        wr_chk(3'b000, 8'h21, 0, 0, 8'h00, 24'h0, "R7 pointer write");
        wr(3'b001, 8'h9A); wr(3'b001, 8'hBC);
        wr_chk(3'b001, 8'hDE, 1, 0, 8'h21, 24'h9ABCDE, "R7 restart at red");

        // R8: overlay writes, valid and invalid pointers
        wr(3'b100, 8'h05);
        wr(3'b101, 8'h0A); wr(3'b101, 8'h0B);
        wr_chk(3'b101, 8'h0C, 0, 1, 8'h05, 24'h0A0B0C, "R8 overlay 5");
        wr(3'b100, 8'h00);
        wr(3'b101, 8'h1A); wr(3'b101, 8'h1B);
        wr_chk(3'b101, 8'h1C, 0, 0, 8'h00, 24'h0, "R8 overlay 0 ignored");
        wr(3'b100, 8'h10);
        wr(3'b101, 8'h2A); wr(3'b101, 8'h2B);
        wr_chk(3'b101, 8'h2C, 0, 0, 8'h00, 24'h0, "R8 overlay 16 ignored");

        // R9: overlay prefetched read
        wr(3'b111, 8'h05);
        rd(3'b101, 8'h0A, "R9 red");
        rd(3'b101, 8'h0B, "R9 green");
        rd(3'b101, 8'h0C, "R9 blue");
        wr(3'b111, 8'h00);
        rd(3'b111, 8'h01, "R2 read 111");
        rd(3'b101, 8'h00, "R8 invalid reads zero");
        rd(3'b101, 8'h00, "R8 invalid reads zero");
        rd(3'b101, 8'h00, "R8 invalid reads zero");

        // R10: mask and control word
        wr(3'b010, 8'h5A);
        rd(3'b010, 8'h5A, "R10 mask");
        check(pix_mask == 8'h5A, "R10 pix_mask port", {16'h0, pix_mask}, 24'h5A);
        wr(3'b110, 8'h02);
        rd(3'b110, 8'h02, "R10 ctrl");
        check(ctrl_word == 8'h02, "R10 ctrl_word port", {16'h0, ctrl_word}, 24'h02);

        // R11: narrow components
        wr(3'b000, 8'h30);
        wr(3'b001, 8'hFF); wr(3'b001, 8'hC1);
        wr_chk(3'b001, 8'h7F, 1, 0, 8'h30, 24'h3F013F, "R11 narrow store");
        wr(3'b011, 8'h21);
        rd(3'b001, 8'h1A, "R11 narrow red");
        rd(3'b001, 8'h3C, "R11 narrow green");
        rd(3'b001, 8'h1E, "R11 narrow blue");
        wr(3'b110, 8'h00);

        // R12: read data holds without a read strobe
        rd(3'b110, 8'h00, "R12 setup");
        wr(3'b010, 8'hC3);
        idle(3);
        check(rdata == 8'h00, "R12 hold", {16'h0, rdata}, 24'h00);

        // R13: simultaneous strobes
        sel = 3'b010; wdata = 8'h33; wr_stb = 1'b1; rd_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b0;
        @(negedge clk);
        check(rdata == 8'h00, "R13 rdata unchanged", {16'h0, rdata}, 24'h00);
        rd(3'b010, 8'h33, "R13 write applied");
        idle(2);
        finish_run();
    end
endmodule